// File: doc/BRIEF.md
# Loadable Virtual Timebase

This block turns a free-running counter into a settable virtual clock. The counter itself can only be cleared, never loaded. An offset register closes the gap: the virtual time on the output is the counter value plus the offset, taken modulo 2^W. A divider advances the counter once every 2^PRE_LOG2 clock cycles.

A load request starts a short sequence in a four-state controller. In `SEQ_IDLE` a request is accepted and the offset is captured (IDLE to HALT). `SEQ_HALT` stops counting (HALT to ZERO). `SEQ_ZERO` clears the counter and the divider, parks the deadline compare at the new time minus one, disarms deadline matching, and places the wrap compare at zero minus the offset (ZERO to RESUME). `SEQ_RESUME` starts counting again (RESUME to IDLE). `busy` is high in the three non-idle states.

A deadline is written in virtual time. The block keeps it for readback and loads the hardware compare with the deadline minus the offset. Two compare channels, one for the deadline and one for the wrap point, each produce a one-cycle pulse when the counter steps onto them. A mask input silences the deadline pulse and leaves the stored deadline alone. The wrap pulse is always enabled.

Top module: `vtime_unit`

## Requirements
- R1: After reset, `busy`, `dl_hit` and `vwrap` are low, `dl_rdbk` is all ones, deadline matching is disarmed, and `vtime` reads 0 on the first cycle after reset is released.
- R2: `vtime` equals counter plus offset modulo 2^W. When a load finishes, meaning the first cycle with `busy` low, `vtime` equals the loaded value. It then rises by exactly 1 every 2^PRE_LOG2 cycles, with the first step 2^PRE_LOG2 cycles after `busy` falls, and wraps from all ones to 0.
- R3: A load keeps `busy` high for exactly 3 cycles. A `set_req` seen while `busy` is high is ignored.
- R4: A deadline written while `busy` is low is returned unchanged on `dl_rdbk` in virtual time, not offset-adjusted, and it arms deadline matching.
- R5: A deadline write seen while `busy` is high is ignored. `dl_rdbk` is unchanged and no match is armed.
- R6: `dl_hit` pulses for one cycle, in the same cycle that `vtime` steps onto the armed, unmasked deadline.
- R7: While `dl_mask` is high, `dl_hit` stays low, and `dl_rdbk` keeps the stored deadline.
- R8: A load disarms deadline matching. No `dl_hit` occurs until a new deadline is written, and the load does not change `dl_rdbk`.
- R9: `vwrap` pulses for one cycle in the cycle that `vtime` steps onto 0.
- R10: When the deadline step and the wrap step fall on the same counter step, `dl_hit` and `vwrap` pulse in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| set_req | input | 1 | Start a load of virtual time |
| set_time | input | W | Virtual time to load |
| dl_wr | input | 1 | Write a deadline |
| dl_time | input | W | Deadline in virtual time |
| dl_mask | input | 1 | Suppress deadline pulses |
| busy | output | 1 | Load sequence in progress |
| vtime | output | W | Current virtual time |
| dl_rdbk | output | W | Stored virtual deadline |
| dl_hit | output | 1 | Deadline match pulse |
| vwrap | output | 1 | Virtual wrap pulse |

## Verification
The properties take for granted a divider of at least two cycles per step (PRE_LOG2 of 1 or more), so two pulses on one channel can never come back to back. The match and wrap properties are only claimed in idle cycles where no deadline write landed on the edge before, because a load or write on that edge legally moves the offset or the stored deadline under a pulse. The stimulus therefore drives writes and loads only on falling edges, and judges pulses only inside windows that open after `busy` has fallen. Deliberate writes and load requests during `busy` exercise the ignore paths.

// File: rtl/vtb_pkg.sv
package vtb_pkg;

    // Load sequencer states
    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_HALT   = 2'd1,
        SEQ_ZERO   = 2'd2,
        SEQ_RESUME = 2'd3
    } seq_state_t;

    // Compare channel indices: deadline first, wrap second
    localparam int CH_DL   = 0;
    localparam int CH_WRAP = 1;
    localparam int N_CH    = 2;

endpackage

// File: rtl/vtb_count.sv
// Clear-only counter with step divider and per-channel compare units.
module vtb_count #(
    parameter int W        = 32,
    parameter int PRE_LOG2 = 2,
    parameter int NCH      = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    halt,
    input  logic                    resume,
    input  logic                    zero,
    input  logic [NCH-1:0][W-1:0]   cmp,
    output logic [W-1:0]            cnt,
    output logic [NCH-1:0]          hit
);

    localparam int DIV_W = (PRE_LOG2 < 1) ? 1 : PRE_LOG2;

    logic             run;
    logic [DIV_W-1:0] div;
    logic             step;
    logic [W-1:0]     cnt_nx;

    assign step   = run && (&div);
    assign cnt_nx = cnt + W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b1;
        end else if (halt) begin
            run <= 1'b0;
        end else if (resume) begin
            run <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || zero) begin
            div <= '0;
        end else if (run) begin
            div <= div + DIV_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || zero) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= cnt_nx;
        end
    end

    // One comparator per channel: fires when the counter steps onto it
    for (genvar i = 0; i < NCH; i++) begin : g_cmp
        assign hit[i] = step && (cnt_nx == cmp[i]);
    end

endmodule

// File: rtl/vtb_seq.sv
// Load sequencer: halt, zero, resume.
module vtb_seq
    import vtb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    output logic busy,
    output logic take,
    output logic halt,
    output logic zero,
    output logic resume
);

    seq_state_t state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        busy     = 1'b1;
        take     = 1'b0;
        halt     = 1'b0;
        zero     = 1'b0;
        resume   = 1'b0;
        unique case (state)
            SEQ_IDLE: begin
                busy = 1'b0;
                if (set_req) begin
                    take     = 1'b1;
                    state_nx = SEQ_HALT;
                end
            end
            SEQ_HALT: begin
                halt     = 1'b1;
                state_nx = SEQ_ZERO;
            end
            SEQ_ZERO: begin
                zero     = 1'b1;
                state_nx = SEQ_RESUME;
            end
            SEQ_RESUME: begin
                resume   = 1'b1;
                state_nx = SEQ_IDLE;
            end
            default: state_nx = SEQ_IDLE;
        endcase
    end

endmodule

// File: rtl/vtime_unit.sv
// Settable virtual timebase on top of a clear-only counter.
module vtime_unit
    import vtb_pkg::*;
#(
    parameter int W        = 32,
    parameter int PRE_LOG2 = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_req,
    input  logic [W-1:0] set_time,
    input  logic         dl_wr,
    input  logic [W-1:0] dl_time,
    input  logic         dl_mask,
    output logic         busy,
    output logic [W-1:0] vtime,
    output logic [W-1:0] dl_rdbk,
    output logic         dl_hit,
    output logic         vwrap
);

    logic                  take, halt, zero, resume;
    logic [W-1:0]          offset;
    logic [W-1:0]          cnt;
    logic [N_CH-1:0][W-1:0] cmp;
    logic [N_CH-1:0]       hit;
    logic                  dl_arm;
    logic                  dl_acc;

    vtb_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_req(set_req),
        .busy   (busy),
        .take   (take),
        .halt   (halt),
        .zero   (zero),
        .resume (resume)
    );

    vtb_count #(
        .W       (W),
        .PRE_LOG2(PRE_LOG2),
        .NCH     (N_CH)
    ) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .halt  (halt),
        .resume(resume),
        .zero  (zero),
        .cmp   (cmp),
        .cnt   (cnt),
        .hit   (hit)
    );

    assign dl_acc = dl_wr && !busy;
    assign vtime  = cnt + offset;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            offset <= '0;
        end else if (take) begin
            offset <= set_time;
        end
    end

    // Deadline channel: stored virtual value, hardware compare, arm flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dl_rdbk      <= '1;
            cmp[CH_DL]   <= '1;
            dl_arm       <= 1'b0;
        end else if (zero) begin
            cmp[CH_DL]   <= offset - W'(1);
            dl_arm       <= 1'b0;
        end else if (dl_acc) begin
            dl_rdbk      <= dl_time;
            cmp[CH_DL]   <= dl_time - offset;
            dl_arm       <= 1'b1;
        end
    end

    // Wrap channel: compare sits where counter plus offset becomes zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp[CH_WRAP] <= '0;
        end else if (zero) begin
            cmp[CH_WRAP] <= '0 - offset;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dl_hit <= 1'b0;
            vwrap  <= 1'b0;
        end else begin
            dl_hit <= hit[CH_DL] && dl_arm && !dl_mask;
            vwrap  <= hit[CH_WRAP];
        end
    end

endmodule

// File: rtl/vtime_unit_chk.sv
module vtime_unit_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         dl_wr,
    input logic         dl_mask,
    input logic         busy,
    input logic [W-1:0] vtime,
    input logic [W-1:0] dl_rdbk,
    input logic         dl_hit,
    input logic         vwrap
);

    assert_busy_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy ##1 busy ##1 !busy);

    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |->
            (vtime == $past(vtime) || vtime == ($past(vtime) + W'(1))));

    assert_rdbk_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(dl_rdbk));

    assert_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dl_mask |=> !dl_hit);

    assert_hit_at_dl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dl_hit && !busy && !$past(dl_wr)) |-> (vtime == dl_rdbk));

    assert_wrap_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (vwrap && !busy) |-> (vtime == '0));

    assert_wrap_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        vwrap |=> !vwrap);

endmodule

bind vtime_unit vtime_unit_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .dl_wr  (dl_wr),
    .dl_mask(dl_mask),
    .busy   (busy),
    .vtime  (vtime),
    .dl_rdbk(dl_rdbk),
    .dl_hit (dl_hit),
    .vwrap  (vwrap)
);

// File: tb/test_vtime_unit.sv
module test_vtime_unit;

    localparam int W    = 32;
    localparam int PRE  = 2;
    localparam int STEP = 1 << PRE;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         set_req;
    logic [W-1:0] set_time;
    logic         dl_wr;
    logic [W-1:0] dl_time;
    logic         dl_mask;
    logic         busy;
    logic [W-1:0] vtime;
    logic [W-1:0] dl_rdbk;
    logic         dl_hit;
    logic         vwrap;

    always #10 clk = ~clk;   // 50 MHz

    vtime_unit #(.W(W), .PRE_LOG2(PRE)) i_vtime_unit (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (set_req),
        .set_time(set_time),
        .dl_wr   (dl_wr),
        .dl_time (dl_time),
        .dl_mask (dl_mask),
        .busy    (busy),
        .vtime   (vtime),
        .dl_rdbk (dl_rdbk),
        .dl_hit  (dl_hit),
        .vwrap   (vwrap)
    );

    typedef struct {
        int           at;
        logic [W-1:0] vt;
        bit           m;
        bit           o;
        string        req;
    } item_t;

    item_t q[$];
    int    cyc    = 0;
    int    errs   = 0;
    int    checks = 0;
    bit    done   = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Monitor: pops expected items and compares in their cycle
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].at < cyc) begin
            item_t lost;
            lost = q.pop_front();
            chk(1'b0, lost.req, "missed sample", W'(cyc), W'(lost.at));
        end
        if (q.size() > 0 && q[0].at == cyc) begin
            item_t it;
            it = q.pop_front();
            chk(vtime == it.vt, "R2", "vtime", vtime, it.vt);
            chk(dl_hit == it.m, it.req, "dl_hit", W'(dl_hit), W'(it.m));
            chk(vwrap == it.o, it.req, "vwrap", W'(vwrap), W'(it.o));
        end
    end

    // mode 1: deadline write during busy (R5); mode 2: second load request during busy (R3)
    task automatic do_set(input logic [W-1:0] ts, input int mode,
                          input logic [W-1:0] other);
        int n;
        set_req  = 1'b1;
        set_time = ts;
        @(negedge clk);
        set_req = 1'b0;
        n = 0;
        while (busy && n < 10) begin
            n++;
            if (n == 1 && mode == 1) begin
                dl_wr   = 1'b1;
                dl_time = other;
            end
            if (n == 1 && mode == 2) begin
                set_req  = 1'b1;
                set_time = other;
            end
            @(negedge clk);
            dl_wr   = 1'b0;
            set_req = 1'b0;
        end
        chk(n == 3, "R3", "busy length", W'(n), W'(3));
    endtask

    // Called at the first negedge with busy low; pushes one item per cycle
    task automatic window(input logic [W-1:0] ts, input bit wr,
                          input logic [W-1:0] dl, input bit mask,
                          input bit armed, input int len, input string req);
        int base;
        base    = cyc;
        dl_wr   = wr;
        dl_time = dl;
        dl_mask = mask;
        for (int j = 1; j <= len; j++) begin
            item_t it;
            it.at  = base + j;
            it.vt  = ts + W'(j / STEP);
            it.m   = armed && !mask && (j % STEP == 0) && (it.vt == dl);
            it.o   = (j % STEP == 0) && (it.vt == '0);
            it.req = req;
            q.push_back(it);
        end
        @(negedge clk);
        dl_wr = 1'b0;
        repeat (len) @(negedge clk);
        dl_mask = 1'b0;
    endtask

    initial begin
        rst_n    = 1'b0;
        set_req  = 1'b0;
        set_time = '0;
        dl_wr    = 1'b0;
        dl_time  = '0;
        dl_mask  = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(busy == 1'b0, "R1", "busy", W'(busy), '0);
        chk(dl_hit == 1'b0, "R1", "dl_hit", W'(dl_hit), '0);
        chk(vwrap == 1'b0, "R1", "vwrap", W'(vwrap), '0);
        chk(dl_rdbk == '1, "R1", "dl_rdbk", dl_rdbk, '1);
        chk(vtime == '0, "R1", "vtime", vtime, '0);

        // R2, R4, R6: load, write deadline, match when reached
        do_set(32'd1000, 0, '0);
        window(32'd1000, 1'b1, 32'd1003, 1'b0, 1'b1, 20, "R6");
        chk(dl_rdbk == 32'd1003, "R4", "dl_rdbk", dl_rdbk, 32'd1003);

        // R5, R8: write during busy ignored; load disarms old deadline
        do_set(32'd1000, 1, 32'd1001);
        window(32'd1000, 1'b0, 32'd1003, 1'b0, 1'b0, 20, "R8");
        chk(dl_rdbk == 32'd1003, "R5", "dl_rdbk after busy write", dl_rdbk, 32'd1003);

        // R7: masked deadline
        do_set(32'h10, 0, '0);
        window(32'h10, 1'b1, 32'h12, 1'b1, 1'b1, 16, "R7");
        chk(dl_rdbk == 32'h12, "R7", "dl_rdbk under mask", dl_rdbk, 32'h12);

        // R3: second load request during busy ignored
        do_set(32'd500, 2, 32'd9000);
        window(32'd500, 1'b0, 32'h12, 1'b0, 1'b0, 8, "R3");

        // R9: virtual wrap
        do_set(32'hFFFF_FFFE, 0, '0);
        window(32'hFFFF_FFFE, 1'b0, 32'h12, 1'b0, 1'b0, 12, "R9");

        // R10: deadline at zero coincides with wrap
        do_set(32'hFFFF_FFFD, 0, '0);
        window(32'hFFFF_FFFD, 1'b1, 32'h0, 1'b0, 1'b1, 16, "R10");

        repeat (2) @(negedge clk);
        chk(q.size() == 0, "R2", "pending items", W'(q.size()), '0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog R2 actual=%0d expected=%0d", cyc, 0);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule